// File: doc/BRIEF.md
# Multiplexed Bus Write Cycle Sequencer

This block produces the clock-by-clock signal timing of a single write transfer on a bus whose low address byte and data byte share one set of eight lines. A requester offers a 16-bit address, one data byte and a flag that picks an I/O write or a memory write. When the sequencer is idle it takes the request and runs the cycle through the states T1, T2, zero or more wait states, and T3. In T1 it pulses the address latch enable and puts the low address on the shared lines. From T2 onwards it puts the data byte on those lines and pulls the active-low write strobe down.

The high address byte and the cycle status are held for the whole cycle. The status consists of the I/O-or-memory level and the two cycle-type bits, which read 0 and 1 for a write. A slow target stretches the cycle by holding the ready input low. The sequencer samples ready on the clock edge that ends T2 and on the edge that ends each wait state. A done pulse marks T3, and the bus is released on the following cycle.

Top module: `bus_write_seq`

## Requirements
- R1: After reset, and whenever no cycle is running, every bus output is released or inactive: ad_oe=0, a_hi_oe=0, ale=0, wr_n=1, done=0, io_m=0, st1=0 and st0=0.
- R2: A request present while idle (req_valid=1) begins T1 on the next clock. A request offered while a cycle runs, including during T3, is ignored.
- R3: ale is 1 only in T1. In T1, ad_out carries req_addr[7:0] with ad_oe=1.
- R4: From T2 through T3, including all wait states, ad_out carries the data byte with ad_oe=1.
- R5: From T1 to the end of T3, a_hi carries req_addr[15:8] with a_hi_oe=1.
- R6: For the whole cycle io_m equals the select captured with the request (1 = I/O write, 0 = memory write), and st1=0, st0=1.
- R7: wr_n is 0 in T2 and in every wait state. It is 1 in T1 and T3.
- R8: ready is sampled only on the edges that end T2 and each wait state. A low sample adds another wait state and a high sample moves to T3, so the number of wait states equals the number of consecutive low samples. The ready level at any other time has no effect.
- R9: done is 1 for exactly the T3 cycle. The next cycle is idle, with the bus released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Write request present |
| req_addr | input | 16 | Target address |
| req_data | input | 8 | Byte to write |
| req_io | input | 1 | 1 = I/O write, 0 = memory write |
| ready | input | 1 | Target ready, low stretches the cycle |
| ale | output | 1 | Address latch enable pulse in T1 |
| ad_out | output | 8 | Shared low-address / data lines |
| ad_oe | output | 1 | Drive enable for ad_out |
| a_hi | output | 8 | High address byte |
| a_hi_oe | output | 1 | Drive enable for a_hi |
| wr_n | output | 1 | Active-low write strobe |
| io_m | output | 1 | I/O-or-memory status level |
| st1 | output | 1 | Cycle status bit 1 |
| st0 | output | 1 | Cycle status bit 0 |
| done | output | 1 | High during T3 |

## Verification
The main stimulus is a stream of random writes. Each write has a random address, data byte, select and wait-state count from 0 to 3. These cases separate the low-address phase from the data phase on the shared lines, and they show that io_m follows the select without altering the timing. Directed cases cover the rest:
- A cycle with no wait states and a long stretch of five, which check that ready is counted only at the sampling edges.
- ready held high during T1 and T3, which must neither shorten nor lengthen the cycle.
- A second request offered through T2 and T3, which must not start a cycle.

// File: rtl/bwseq_pkg.sv
package bwseq_pkg;

    typedef enum logic [2:0] {
        CS_IDLE = 3'd0,
        CS_T1   = 3'd1,
        CS_T2   = 3'd2,
        CS_TW   = 3'd3,
        CS_T3   = 3'd4
    } cyc_state_e;

    typedef struct packed {
        logic io_m;
        logic st1;
        logic st0;
    } cyc_status_t;

    localparam cyc_status_t STATUS_NONE = '{io_m: 1'b0, st1: 1'b0, st0: 1'b0};

    function automatic cyc_status_t write_status(input logic is_io);
        cyc_status_t s;
        s.io_m = is_io;
        s.st1  = 1'b0;
        s.st0  = 1'b1;
        return s;
    endfunction

    function automatic logic in_cycle(input cyc_state_e s);
        return s != CS_IDLE;
    endfunction

endpackage

// File: rtl/bwseq_fsm.sv
module bwseq_fsm
    import bwseq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       req_valid,
    input  logic       ready,
    output cyc_state_e state,
    output logic       accept
);

    cyc_state_e state_q, state_d;

    always_comb accept = req_valid && (state_q == CS_IDLE);

    always_comb begin
        state_d = state_q;
        case (state_q)
            CS_IDLE: if (req_valid) state_d = CS_T1;
            CS_T1:   state_d = CS_T2;
            CS_T2,
            CS_TW:   state_d = ready ? CS_T3 : CS_TW;
            CS_T3:   state_d = CS_IDLE;
            default: state_d = CS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= CS_IDLE;
        else     state_q <= state_d;
    end

    assign state = state_q;

    assert_start_R2: assert property (@(posedge clk) disable iff (rst)
        (state_q == CS_IDLE && req_valid) |=> (state_q == CS_T1));

    assert_t1_to_t2_R8: assert property (@(posedge clk) disable iff (rst)
        (state_q == CS_T1) |=> (state_q == CS_T2));

    assert_stretch_R8: assert property (@(posedge clk) disable iff (rst)
        ((state_q == CS_T2 || state_q == CS_TW) && !ready) |=> (state_q == CS_TW));

    assert_finish_R8: assert property (@(posedge clk) disable iff (rst)
        ((state_q == CS_T2 || state_q == CS_TW) && ready) |=> (state_q == CS_T3));

    assert_t3_end_R9: assert property (@(posedge clk) disable iff (rst)
        (state_q == CS_T3) |=> (state_q == CS_IDLE));

endmodule

// File: rtl/bwseq_req_hold.sv
module bwseq_req_hold #(
    parameter int ADDR_W = 16,
    parameter int BUS_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [BUS_W-1:0]  in_data,
    input  logic              in_io,
    output logic [ADDR_W-1:0] addr,
    output logic [BUS_W-1:0]  data,
    output logic              is_io
);

    always_ff @(posedge clk) begin
        if (rst) begin
            addr  <= '0;
            data  <= '0;
            is_io <= 1'b0;
        end else if (accept) begin
            addr  <= in_addr;
            data  <= in_data;
            is_io <= in_io;
        end
    end

    assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !accept |=> ($stable(addr) && $stable(data) && $stable(is_io)));

endmodule

// File: rtl/bwseq_drive.sv
module bwseq_drive
    import bwseq_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int BUS_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  cyc_state_e        state,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BUS_W-1:0]  data,
    input  logic              is_io,
    output logic              ale,
    output logic [BUS_W-1:0]  ad_out,
    output logic              ad_oe,
    output logic [ADDR_W-BUS_W-1:0] a_hi,
    output logic              a_hi_oe,
    output logic              wr_n,
    output cyc_status_t       status,
    output logic              done
);

    localparam int HI_W = ADDR_W - BUS_W;

    logic [HI_W-1:0] hi_part;

    generate
        if (HI_W > 0) begin : g_hi
            assign hi_part = addr[ADDR_W-1:BUS_W];
        end else begin : g_nohi
            assign hi_part = '0;
        end
    endgenerate

    always_comb begin
        ale     = 1'b0;
        ad_out  = '0;
        ad_oe   = 1'b0;
        a_hi    = '0;
        a_hi_oe = 1'b0;
        wr_n    = 1'b1;
        done    = 1'b0;
        status  = STATUS_NONE;
        if (in_cycle(state)) begin
            a_hi    = hi_part;
            a_hi_oe = 1'b1;
            ad_oe   = 1'b1;
            status  = write_status(is_io);
        end
        case (state)
            CS_T1: begin
                ale    = 1'b1;
                ad_out = addr[BUS_W-1:0];
            end
            CS_T2, CS_TW: begin
                ad_out = data;
                wr_n   = 1'b0;
            end
            CS_T3: begin
                ad_out = data;
                done   = 1'b1;
            end
            default: ;
        endcase
    end

    assert_strobe_driven_R7: assert property (@(posedge clk) disable iff (rst)
        !wr_n |-> (ad_oe && a_hi_oe && !ale));

    assert_ale_then_strobe_R3: assert property (@(posedge clk) disable iff (rst)
        ale |=> (!ale && !wr_n));

    assert_data_steady_R4: assert property (@(posedge clk) disable iff (rst)
        (ad_oe && !ale && $past(ad_oe) && !$past(ale)) |-> $stable(ad_out));

    assert_status_steady_R6: assert property (@(posedge clk) disable iff (rst)
        (a_hi_oe && $past(a_hi_oe)) |-> ($stable(status) && $stable(a_hi)));

    assert_done_release_R9: assert property (@(posedge clk) disable iff (rst)
        done |=> (!ad_oe && !a_hi_oe && !done));

endmodule

// File: rtl/bus_write_seq.sv
module bus_write_seq
    import bwseq_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int BUS_W  = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    req_valid,
    input  logic [ADDR_W-1:0]       req_addr,
    input  logic [BUS_W-1:0]        req_data,
    input  logic                    req_io,
    input  logic                    ready,
    output logic                    ale,
    output logic [BUS_W-1:0]        ad_out,
    output logic                    ad_oe,
    output logic [ADDR_W-BUS_W-1:0] a_hi,
    output logic                    a_hi_oe,
    output logic                    wr_n,
    output logic                    io_m,
    output logic                    st1,
    output logic                    st0,
    output logic                    done
);

    cyc_state_e        state;
    logic              accept;
    logic [ADDR_W-1:0] h_addr;
    logic [BUS_W-1:0]  h_data;
    logic              h_io;
    cyc_status_t       status;

    bwseq_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .ready     (ready),
        .state     (state),
        .accept    (accept)
    );

    bwseq_req_hold #(.ADDR_W(ADDR_W), .BUS_W(BUS_W)) u_hold (
        .clk     (clk),
        .rst     (rst),
        .accept  (accept),
        .in_addr (req_addr),
        .in_data (req_data),
        .in_io   (req_io),
        .addr    (h_addr),
        .data    (h_data),
        .is_io   (h_io)
    );

    bwseq_drive #(.ADDR_W(ADDR_W), .BUS_W(BUS_W)) u_drive (
        .clk     (clk),
        .rst     (rst),
        .state   (state),
        .addr    (h_addr),
        .data    (h_data),
        .is_io   (h_io),
        .ale     (ale),
        .ad_out  (ad_out),
        .ad_oe   (ad_oe),
        .a_hi    (a_hi),
        .a_hi_oe (a_hi_oe),
        .wr_n    (wr_n),
        .status  (status),
        .done    (done)
    );

    assign io_m = status.io_m;
    assign st1  = status.st1;
    assign st0  = status.st0;

    assert_write_status_R6: assert property (@(posedge clk) disable iff (rst)
        ad_oe |-> (!st1 && st0));

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        !a_hi_oe |-> (!ad_oe && !ale && wr_n && !done && !st0));

endmodule

// File: tb/sim_bus_write_seq.sv
module sim_bus_write_seq;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [15:0] req_addr = '0;
    logic [7:0]  req_data = '0;
    logic        req_io = 1'b0;
    logic        ready = 1'b1;
    logic        ale, ad_oe, a_hi_oe, wr_n, io_m, st1, st0, done;
    logic [7:0]  ad_out, a_hi;

    int n_chk  = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    bus_write_seq u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
        .req_data(req_data), .req_io(req_io), .ready(ready), .ale(ale),
        .ad_out(ad_out), .ad_oe(ad_oe), .a_hi(a_hi), .a_hi_oe(a_hi_oe),
        .wr_n(wr_n), .io_m(io_m), .st1(st1), .st0(st0), .done(done)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Expected outputs per phase: 0 idle, 1 T1, 2 T2 or wait, 3 T3
    function automatic logic [7:0] exp_ad(input int ph, input logic [15:0] a, input logic [7:0] d);
        if (ph == 1) return a[7:0];
        if (ph >= 2) return d;
        return 8'h00;
    endfunction

    function automatic logic exp_wr_n(input int ph);
        return !(ph == 2);
    endfunction

    task automatic check_phase(input int ph, input logic [15:0] a, input logic [7:0] d, input logic io);
        bit act = (ph != 0);
        if (!act) begin
            chk("R1 ad_oe idle", ad_oe, 0);
            chk("R1 a_hi_oe idle", a_hi_oe, 0);
            chk("R1 ale idle", ale, 0);
            chk("R1 wr_n idle", wr_n, 1);
            chk("R1 done idle", done, 0);
            chk("R1 status idle", {io_m, st1, st0}, 3'b000);
        end else begin
            chk("R3 ale", ale, ph == 1);
            if (ph == 1) chk("R3 low address", {ad_oe, ad_out}, {1'b1, exp_ad(ph, a, d)});
            else         chk("R4 data byte", {ad_oe, ad_out}, {1'b1, exp_ad(ph, a, d)});
            chk("R5 high address", {a_hi_oe, a_hi}, {1'b1, a[15:8]});
            chk("R6 status", {io_m, st1, st0}, {io, 2'b01});
            chk("R7 strobe", wr_n, exp_wr_n(ph));
            chk("R9 done", done, ph == 3);
        end
    endtask

    // One write; intrude=1 offers a second request through T2 and T3 (R2)
    task automatic do_write(input logic [15:0] a, input logic [7:0] d, input logic io,
                            input int waits, input bit intrude);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_data = d; req_io = io;
        ready = $urandom_range(0, 1);
        @(negedge clk);
        req_valid = 1'b0;
        req_addr = ~a; req_data = ~d; req_io = ~io;
        check_phase(1, a, d, io);            // R2: T1 follows acceptance
        ready = 1'b1;                        // R8: ignored in T1
        @(negedge clk);
        check_phase(2, a, d, io);
        ready = (waits == 0);
        if (intrude) req_valid = 1'b1;
        for (int k = 0; k < waits; k++) begin
            @(negedge clk);
            check_phase(2, a, d, io);        // R8: wait state
            ready = (k == waits - 1);
        end
        @(negedge clk);
        check_phase(3, a, d, io);            // R8: T3 after first high sample
        ready = 1'b1;
        req_valid = 1'b0;
        @(negedge clk);
        check_phase(0, a, d, io);            // R9 release; R2 intrusion ignored
        ready = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'h1357_2468));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check_phase(0, '0, '0, 0);           // R1 reset state
        // R8 ready low while idle and no request: stays idle
        ready = 1'b0;
        @(negedge clk);
        check_phase(0, '0, '0, 0);
        do_write(16'hA55A, 8'h3C, 1'b0, 0, 0);   // memory, no wait
        do_write(16'h12F0, 8'hC3, 1'b1, 0, 0);   // I/O, no wait
        do_write(16'hFFFF, 8'h00, 1'b1, 5, 0);   // long stretch R8
        do_write(16'h0001, 8'hFF, 1'b0, 1, 1);   // R2 intrusion
        do_write(16'h8000, 8'h81, 1'b1, 2, 1);
        for (int i = 0; i < 40; i++) begin
            do_write(16'($urandom), 8'($urandom), 1'($urandom),
                     int'($urandom_range(0, 3)), bit'($urandom_range(0, 1)));
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule